// File: doc/BRIEF.md
# Three-Stream Lock-Step Pixel Joiner

This block brings three AXI4-Stream video sources into step so that the pixels at the same raster position in each can be combined. Each source lands in its own shallow queue. Until a source delivers a pixel flagged as frame start on `tuser`, that source is drained and its data dropped. Left-over words from an earlier read burst therefore never reach the queue. From the frame-start pixel onward, every accepted pixel of that source is queued in order.

A pixel triple is taken from the three queue heads only when all three queues hold data. If one source lags, the other two wait for it. Each triple passes through a two-stage pipeline that applies one of four pixel operations, chosen by a mode input. A valid flag travels with the data through that pipeline. The block's output is a write strobe, a result pixel and a frame-start flag, meant to feed an output buffer. A `frame_restart` pulse drops all queued and in-flight data and sends every source back to waiting for frame start.

Top module: `tri_frame_joiner`

## Requirements
- R1: After reset, `m_valid` is low and all three `sN_tready` outputs are high.
- R2: While a source is waiting for frame start, its `tready` stays high and every pixel with `tuser`=0 is dropped, so it never contributes to any output.
- R3: The first pixel a source queues is the one accepted with `tuser`=1. After that, every handshaked pixel of that source is queued in arrival order.
- R4: With a queue depth D (default 16), a queuing source drops `tready` once D-2 pixels are held, and a queue never overflows.
- R5: A triple is consumed only when all three queues are non-empty. While any queue is empty, no result is produced.
- R6: A triple whose last pixel is accepted at clock edge k, with the other two already queued, raises `m_valid` after edge k+2.
- R7: Mode 0 gives the sum of A and B, clamped to the all-ones value (255 for 8-bit pixels).
- R8: Mode 1 gives |A-B|.
- R9: Mode 2 gives the maximum of A, B and C.
- R10: Mode 3 gives the minimum of A, B and C.
- R11: `m_sof` is high with the result of the triple formed from the three frame-start pixels, and low for every later triple of that frame.
- R12: One cycle of `frame_restart` empties all queues, returns every source to waiting for frame start, and forces `m_valid` low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_restart | input | 1 | Synchronous drop of all queued data; every source returns to waiting for frame start |
| mode | input | 2 | Pixel operation: 0 clamped A+B, 1 absolute A-B, 2 max of three, 3 min of three |
| s0_tdata | input | PIX_W | Source A pixel |
| s0_tvalid | input | 1 | Source A valid |
| s0_tuser | input | 1 | Source A frame-start flag |
| s0_tready | output | 1 | Source A ready |
| s1_tdata | input | PIX_W | Source B pixel |
| s1_tvalid | input | 1 | Source B valid |
| s1_tuser | input | 1 | Source B frame-start flag |
| s1_tready | output | 1 | Source B ready |
| s2_tdata | input | PIX_W | Source C pixel |
| s2_tvalid | input | 1 | Source C valid |
| s2_tuser | input | 1 | Source C frame-start flag |
| s2_tready | output | 1 | Source C ready |
| m_valid | output | 1 | Result strobe (write enable for the downstream buffer) |
| m_data | output | PIX_W | Result pixel |
| m_sof | output | 1 | Result is the first of a frame |

## Verification
The assertions assume that each source follows the stream rule: once `tvalid` is raised, it is held with the same data until the handshake completes. They also assume that `mode` does not change while a triple sits between the two pipeline stages. The bench's stream drivers keep `tvalid` and the data fixed until they see `tready` high just before an edge. They insert idle cycles only between beats. The bench changes `mode` only after a restart, while nothing is in flight. The clamp and maximum checks compare each result with the operands held in the first stage, so they rely on that stable mode.

// File: rtl/tfj_pkg.sv
package tfj_pkg;
   typedef enum logic [1:0] {
      OP_SATSUM  = 2'd0,
      OP_ABSDIFF = 2'd1,
      OP_MAX3    = 2'd2,
      OP_MIN3    = 2'd3
   } tfj_op_e;

   localparam int NUM_SRC = 3;
endpackage

// File: rtl/tfj_fifo.sv
module tfj_fifo #(
   parameter int W        = 9,
   parameter int DEPTH    = 16,
   parameter int AF_LEVEL = 14
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         almost_full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("tfj_fifo: DEPTH must be a power of two, at least 4");
      end
      if (AF_LEVEL < 1 || AF_LEVEL > DEPTH) begin : g_bad_af
         $error("tfj_fifo: AF_LEVEL must lie in 1..DEPTH");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign dout        = mem[rd_ptr];
   assign empty       = (count == '0);
   assign almost_full = (count >= CW'(AF_LEVEL));

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (push && !clr) |-> (int'(count) < DEPTH)); // R4
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      (pop && !clr) |-> (count != '0)); // R5
endmodule

// File: rtl/tfj_path.sv
module tfj_path #(
   parameter int PIX_W     = 8,
   parameter int DEPTH     = 16,
   parameter int AF_MARGIN = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic [PIX_W-1:0] s_tdata,
   input  logic             s_tvalid,
   input  logic             s_tuser,
   output logic             s_tready,
   input  logic             pop,
   output logic [PIX_W-1:0] head_data,
   output logic             head_sof,
   output logic             empty
);
   localparam int AF_LEVEL = DEPTH - AF_MARGIN;

   generate
      if (AF_MARGIN < 1 || AF_MARGIN >= DEPTH) begin : g_bad_margin
         $error("tfj_path: AF_MARGIN must lie in 1..DEPTH-1");
      end
   endgenerate

   logic armed;
   logic accept;
   logic push;
   logic af;
   logic [PIX_W:0] q_out;

   assign s_tready = !armed || !af;
   assign accept   = s_tvalid && s_tready;
   assign push     = accept && (armed || s_tuser) && !clr;

   always_ff @(posedge clk) begin
      if (rst || clr)             armed <= 1'b0;
      else if (accept && s_tuser) armed <= 1'b1;
   end

   tfj_fifo #(
      .W        (PIX_W + 1),
      .DEPTH    (DEPTH),
      .AF_LEVEL (AF_LEVEL)
   ) u_q (
      .clk         (clk),
      .rst         (rst),
      .clr         (clr),
      .push        (push),
      .din         ({s_tuser, s_tdata}),
      .pop         (pop),
      .dout        (q_out),
      .empty       (empty),
      .almost_full (af)
   );

   assign head_data = q_out[PIX_W-1:0];
   assign head_sof  = q_out[PIX_W];

   AST_SOF_ARMS: assert property (@(posedge clk) disable iff (rst)
      (!armed && s_tvalid && s_tuser && !clr) |=> armed); // R3
   AST_HUNT_EMPTY: assert property (@(posedge clk) disable iff (rst)
      (!armed && !$past(push)) |-> empty); // R2
endmodule

// File: rtl/tfj_pixop.sv
module tfj_pixop
   import tfj_pkg::*;
#(
   parameter int PIX_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic [1:0]       mode,
   input  logic             in_valid,
   input  logic [PIX_W-1:0] in_a,
   input  logic [PIX_W-1:0] in_b,
   input  logic [PIX_W-1:0] in_c,
   input  logic             in_sof,
   output logic             out_valid,
   output logic [PIX_W-1:0] out_data,
   output logic             out_sof
);
   logic             s1_valid, s1_sof;
   logic [PIX_W-1:0] s1_a, s1_b, s1_c;
   logic [PIX_W:0]   sum_w;
   logic [PIX_W-1:0] sat_sum, abs_diff, max_ab, min_ab, max3, min3, result;
   tfj_op_e          op;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         s1_valid <= 1'b0;
         s1_sof   <= 1'b0;
      end else begin
         s1_valid <= in_valid;
         s1_sof   <= in_valid && in_sof;
      end
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         s1_a <= in_a;
         s1_b <= in_b;
         s1_c <= in_c;
      end
   end

   assign op       = tfj_op_e'(mode);
   assign sum_w    = {1'b0, s1_a} + {1'b0, s1_b};
   assign sat_sum  = sum_w[PIX_W] ? {PIX_W{1'b1}} : sum_w[PIX_W-1:0];
   assign abs_diff = (s1_a >= s1_b) ? (s1_a - s1_b) : (s1_b - s1_a);
   assign max_ab   = (s1_a >= s1_b) ? s1_a : s1_b;
   assign min_ab   = (s1_a <= s1_b) ? s1_a : s1_b;
   assign max3     = (max_ab >= s1_c) ? max_ab : s1_c;
   assign min3     = (min_ab <= s1_c) ? min_ab : s1_c;

   always_comb begin
      case (op)
         OP_SATSUM:  result = sat_sum;
         OP_ABSDIFF: result = abs_diff;
         OP_MAX3:    result = max3;
         default:    result = min3;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
      end else begin
         out_valid <= s1_valid;
         out_sof   <= s1_sof;
      end
   end

   always_ff @(posedge clk) begin
      if (s1_valid) out_data <= result;
   end

   AST_SUM_BOUND: assert property (@(posedge clk) disable iff (rst)
      (s1_valid && !clr && mode == 2'd0) |=>
         (out_data >= $past(s1_a) && out_data >= $past(s1_b))); // R7
   AST_MAX_BOUND: assert property (@(posedge clk) disable iff (rst)
      (s1_valid && !clr && mode == 2'd2) |=>
         (out_data >= $past(s1_a) && out_data >= $past(s1_b) && out_data >= $past(s1_c))); // R9
endmodule

// File: rtl/tri_frame_joiner.sv
module tri_frame_joiner
   import tfj_pkg::*;
#(
   parameter int PIX_W      = 8,
   parameter int FIFO_DEPTH = 16,
   parameter int AF_MARGIN  = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             frame_restart,
   input  logic [1:0]       mode,
   input  logic [PIX_W-1:0] s0_tdata,
   input  logic             s0_tvalid,
   input  logic             s0_tuser,
   output logic             s0_tready,
   input  logic [PIX_W-1:0] s1_tdata,
   input  logic             s1_tvalid,
   input  logic             s1_tuser,
   output logic             s1_tready,
   input  logic [PIX_W-1:0] s2_tdata,
   input  logic             s2_tvalid,
   input  logic             s2_tuser,
   output logic             s2_tready,
   output logic             m_valid,
   output logic [PIX_W-1:0] m_data,
   output logic             m_sof
);
   generate
      if (PIX_W < 2) begin : g_bad_width
         $error("tri_frame_joiner: PIX_W must be at least 2");
      end
   endgenerate

   logic [PIX_W-1:0]   in_data  [NUM_SRC];
   logic [NUM_SRC-1:0] in_valid, in_user, in_ready;
   logic [PIX_W-1:0]   hd       [NUM_SRC];
   logic [NUM_SRC-1:0] hd_sof, q_empty;
   logic               pop_all;

   assign in_data[0] = s0_tdata;
   assign in_data[1] = s1_tdata;
   assign in_data[2] = s2_tdata;
   assign in_valid   = {s2_tvalid, s1_tvalid, s0_tvalid};
   assign in_user    = {s2_tuser,  s1_tuser,  s0_tuser};
   assign s0_tready  = in_ready[0];
   assign s1_tready  = in_ready[1];
   assign s2_tready  = in_ready[2];

   for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
      tfj_path #(
         .PIX_W     (PIX_W),
         .DEPTH     (FIFO_DEPTH),
         .AF_MARGIN (AF_MARGIN)
      ) u_path (
         .clk       (clk),
         .rst       (rst),
         .clr       (frame_restart),
         .s_tdata   (in_data[gi]),
         .s_tvalid  (in_valid[gi]),
         .s_tuser   (in_user[gi]),
         .s_tready  (in_ready[gi]),
         .pop       (pop_all),
         .head_data (hd[gi]),
         .head_sof  (hd_sof[gi]),
         .empty     (q_empty[gi])
      );
   end

   assign pop_all = ~|q_empty;

   tfj_pixop #(.PIX_W(PIX_W)) u_op (
      .clk       (clk),
      .rst       (rst),
      .clr       (frame_restart),
      .mode      (mode),
      .in_valid  (pop_all),
      .in_a      (hd[0]),
      .in_b      (hd[1]),
      .in_c      (hd[2]),
      .in_sof    (&hd_sof),
      .out_valid (m_valid),
      .out_data  (m_data),
      .out_sof   (m_sof)
   );

   AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (!$past(frame_restart) && !$past(frame_restart, 2)) |->
         (m_valid == $past(pop_all, 2))); // R6
   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
      $past(frame_restart) |-> !m_valid); // R12
   AST_SOF_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
      m_sof |-> m_valid); // R11
endmodule

// File: tb/sim_tri_frame_joiner.sv
module sim_tri_frame_joiner;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       frame_restart = 1'b0;
   logic [1:0] mode = 2'd0;
   logic       s0_tready, s1_tready, s2_tready;
   logic       m_valid, m_sof;
   logic [7:0] m_data;

   always #4 clk = ~clk;

   logic [8:0] stim [3][64];
   logic [7:0] fr   [3][64];
   int         fl   [3];
   int         len  [3];
   int         ptr  [3];
   int         gap  [3];
   int         take_cyc [3];
   logic [2:0] vld  = '0;
   logic [2:0] took = '0;
   logic [2:0] rdy;
   int         cyc = 0;

   logic [7:0] out_d [128];
   logic       out_u [128];
   int         out_c [128];
   int         n_out = 0;

   int nchecks = 0;
   int nerrors = 0;

   tri_frame_joiner u0 (
      .clk(clk), .rst(rst), .frame_restart(frame_restart), .mode(mode),
      .s0_tdata(stim[0][ptr[0]][7:0]), .s0_tvalid(vld[0]), .s0_tuser(stim[0][ptr[0]][8]), .s0_tready(s0_tready),
      .s1_tdata(stim[1][ptr[1]][7:0]), .s1_tvalid(vld[1]), .s1_tuser(stim[1][ptr[1]][8]), .s1_tready(s1_tready),
      .s2_tdata(stim[2][ptr[2]][7:0]), .s2_tvalid(vld[2]), .s2_tuser(stim[2][ptr[2]][8]), .s2_tready(s2_tready),
      .m_valid(m_valid), .m_data(m_data), .m_sof(m_sof)
   );

   assign rdy = {s2_tready, s1_tready, s0_tready};

   always @(posedge clk) cyc <= cyc + 1;

   // stream drivers: hold each beat until taken
   always begin
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
         if (took[p]) begin
            ptr[p]++;
            vld[p] = 1'b0;
            took[p] = 1'b0;
         end
         if (!vld[p] && ptr[p] < len[p] && !(gap[p] != 0 && (cyc % gap[p]) == 0))
            vld[p] = 1'b1;
      end
      #2;
      for (int p = 0; p < 3; p++) begin
         took[p] = vld[p] && rdy[p];
         if (took[p]) take_cyc[p] = cyc;
      end
   end

   always @(negedge clk) begin
      if (m_valid && n_out < 128) begin
         out_d[n_out] = m_data;
         out_u[n_out] = m_sof;
         out_c[n_out] = cyc;
         n_out++;
      end
   end

   function automatic logic [7:0] model(input logic [1:0] m, input logic [7:0] a, b, c);
      logic [8:0] s;
      logic [7:0] r;
      case (m)
         2'd0: begin s = {1'b0, a} + {1'b0, b}; r = s[8] ? 8'hFF : s[7:0]; end
         2'd1: r = (a >= b) ? a - b : b - a;
         2'd2: begin r = (a >= b) ? a : b; if (c > r) r = c; end
         default: begin r = (a <= b) ? a : b; if (c < r) r = c; end
      endcase
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchecks++;
      if (!ok) begin
         nerrors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push_junk(input int p, input logic [7:0] d);
      stim[p][len[p]] = {1'b0, d};
      len[p]++;
   endtask

   task automatic push_frame(input int p, input int n, input int base, input int step);
      for (int i = 0; i < n; i++) begin
         logic [7:0] d;
         d = 8'((base + step * i) & 255);
         stim[p][len[p] + i] = {(i == 0), d};
         fr[p][fl[p] + i] = d;
      end
      len[p] += n;
      fl[p] += n;
   endtask

   // restart the block and clear the stream models
   task automatic restart_clear();
      @(posedge clk); #1;
      frame_restart = 1'b1;
      for (int p = 0; p < 3; p++) begin
         len[p] = 0; ptr[p] = 0; gap[p] = 0; fl[p] = 0; take_cyc[p] = 0;
      end
      vld = '0; took = '0;
      @(posedge clk); #1;
      frame_restart = 1'b0;
      @(negedge clk);
      n_out = 0;
   endtask

   task automatic check_frame(input logic [1:0] m, input int n, input string req);
      chk(n_out == n, {req, " result count"}, n_out, n);
      for (int i = 0; i < n && i < n_out; i++) begin
         chk(out_d[i] == model(m, fr[0][i], fr[1][i], fr[2][i]), req,
             int'(out_d[i]), int'(model(m, fr[0][i], fr[1][i], fr[2][i])));
         chk(out_u[i] == (i == 0), "R11 sof flag", int'(out_u[i]), int'(i == 0));
      end
   endtask

   task automatic sc_reset();
      rst = 1'b1;
      repeat (4) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      chk(m_valid == 1'b0, "R1 valid low", int'(m_valid), 0);
      chk(rdy == 3'b111, "R1 ready high", int'(rdy), 7);
   endtask

   task automatic sc_hunt();
      restart_clear();
      mode = 2'd0;
      push_junk(0, 8'hAA); push_junk(0, 8'hBB); push_junk(0, 8'hCC);
      push_frame(0, 6, 100, 30);
      push_frame(1, 6, 60, 20);
      push_junk(2, 8'h11);
      push_frame(2, 6, 7, 1);
      repeat (80) @(negedge clk);
      // R2 junk dropped, R3 frame-start first, R7 clamped sum
      check_frame(2'd0, 6, "R2 R3 R7 hunt+satsum");
   endtask

   task automatic sc_stall();
      restart_clear();
      mode = 2'd2;
      gap[1] = 2;
      push_frame(0, 10, 3, 17);
      push_frame(1, 10, 200, -13);
      repeat (30) @(negedge clk);
      chk(n_out == 0, "R5 no result while C empty", n_out, 0);
      @(posedge clk); #1;
      gap[2] = 3;
      push_frame(2, 10, 90, 9);
      repeat (100) @(negedge clk);
      check_frame(2'd2, 10, "R5 R9 lockstep max");
   endtask

   task automatic sc_mode(input logic [1:0] m, input string req);
      restart_clear();
      mode = m;
      push_frame(0, 5, 5, 20);
      push_frame(1, 5, 50, 0);
      push_frame(2, 5, 80, -15);
      repeat (50) @(negedge clk);
      check_frame(m, 5, req);
   endtask

   task automatic sc_backpressure();
      restart_clear();
      mode = 2'd0;
      push_frame(0, 20, 1, 3);
      repeat (40) @(negedge clk);
      chk(ptr[0] == 14, "R4 accepted before stall", ptr[0], 14);
      chk(s0_tready == 1'b0, "R4 ready low at threshold", int'(s0_tready), 0);
      chk(n_out == 0, "R5 no result while B,C empty", n_out, 0);
      @(posedge clk); #1;
      push_frame(1, 14, 2, 5);
      push_frame(2, 14, 4, 1);
      repeat (80) @(negedge clk);
      chk(ptr[0] == 20, "R4 remaining accepted after drain", ptr[0], 20);
      check_frame(2'd0, 14, "R4 R7 backpressure data");
   endtask

   task automatic sc_latency();
      restart_clear();
      mode = 2'd3;
      push_frame(0, 1, 40, 0);
      push_frame(1, 1, 30, 0);
      push_frame(2, 1, 35, 0);
      repeat (20) @(negedge clk);
      check_frame(2'd3, 1, "R6 R10 single triple");
      if (n_out >= 1) begin
         int last;
         last = take_cyc[0];
         if (take_cyc[1] > last) last = take_cyc[1];
         if (take_cyc[2] > last) last = take_cyc[2];
         chk(out_c[0] == last + 3, "R6 latency", out_c[0], last + 3);
      end
   endtask

   task automatic sc_restart();
      restart_clear();
      mode = 2'd1;
      push_frame(0, 30, 10, 1);
      push_frame(1, 30, 20, 1);
      push_frame(2, 30, 30, 1);
      while (n_out < 3) @(negedge clk);
      @(posedge clk); #1;
      frame_restart = 1'b1;
      @(posedge clk); #1;
      frame_restart = 1'b0;
      for (int p = 0; p < 3; p++) len[p] = 0;
      vld = '0; took = '0;
      @(negedge clk);
      chk(m_valid == 1'b0, "R12 valid cleared", int'(m_valid), 0);
      chk(rdy == 3'b111, "R12 hunting ready", int'(rdy), 7);
      repeat (10) @(negedge clk);
      chk(m_valid == 1'b0, "R12 nothing left queued", int'(m_valid), 0);
      @(posedge clk); #1;
      for (int p = 0; p < 3; p++) begin
         len[p] = 0; ptr[p] = 0; fl[p] = 0;
      end
      n_out = 0;
      push_junk(0, 8'h55); push_junk(0, 8'h66);
      push_frame(0, 4, 200, 5);
      push_frame(1, 4, 150, 10);
      push_frame(2, 4, 0, 0);
      repeat (40) @(negedge clk);
      check_frame(2'd1, 4, "R12 R8 fresh frame after restart");
   endtask

   initial begin
      #(8 * 150000);
      nerrors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", nchecks, nerrors);
      $finish;
   end

   initial begin
      for (int p = 0; p < 3; p++) begin
         len[p] = 0; ptr[p] = 0; gap[p] = 0; fl[p] = 0; take_cyc[p] = 0;
         for (int i = 0; i < 64; i++) stim[p][i] = '0;
      end
      sc_reset();
      sc_hunt();
      sc_stall();
      sc_mode(2'd1, "R8 absdiff");
      sc_mode(2'd3, "R10 min3");
      sc_backpressure();
      sc_latency();
      sc_restart();
      $display("CHECKS %0d ERRORS %0d", nchecks, nerrors);
      $finish;
   end
endmodule